// File: doc/BRIEF.md
# Complementary PWM Channel with Pulse Counting

This block is a single pulse-width modulation channel. A prescaler divides the system clock. The channel compares a tick counter against a programmed compare value to form a main output and a complementary output. A polarity control selects which level starts each period. Each output also has its own inversion control, and that inversion applies even while the channel is stopped. Configuration arrives over a plain register-write port: address, data and a write strobe.

The channel has two run modes. In free-running mode it repeats periods until software clears the enable. In counting mode it emits a programmed number of periods and then stops: its enable clears by itself and a sticky done flag is raised, which software clears by writing a one. New period and compare values written while the channel runs are held back until the current period ends, so a running waveform never shows a torn period.

Top module: `pwm_pulse_channel`

## Requirements
- R1: After synchronous reset, `pwm_o`, `pwm_n_o`, `running_o` and `irq_o` are all 0.
- R2: With divider value D (address 0x0, bits 7:0), the tick counter advances once every D+1 clock cycles while running.
- R3: With polarity clear, `pwm_o` is high while the tick counter is below the compare value (address 0x2) and low from there up to the period value (address 0x1). The counter then wraps to 0, so one period lasts period+1 ticks. While running, `pwm_n_o` is the opposite of `pwm_o` when both inversions are clear.
- R4: Setting polarity (address 0x4, bit 2) makes the low level come first in each period and the high level second.
- R5: Main inversion (address 0x4, bit 0) and complementary inversion (address 0x4, bit 1) each flip only their own output. They take effect also while stopped, when both un-inverted outputs rest at 0.
- R6: Mode code 0x00 (address 0x3) runs the channel continuously until the enable (address 0x7, bit 0) is written 0.
- R7: Mode code 0x01 stops the channel after N periods. `running_o` falls and `irq_o` rises on the same clock edge. An N of 0 behaves like an N of 1.
- R8: `irq_o` stays set until a write to address 0x8 with bit 0 set. A write there with bit 0 clear has no effect. If the flag is set and cleared on the same edge, the set wins.
- R9: A compare or period value written while running takes effect only at the next period boundary.
- R10: Writing 0 to the enable stops the channel on the next edge, and the outputs return to their stopped levels. A later start begins a fresh period from counter value 0.
- R11: The pulse count N is 14 bits wide. Its bits 7:0 come from address 0x5, bits 7:0. Its bits 13:8 come from address 0x6, bits 5:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 1 | Main waveform output |
| pwm_n_o | output | 1 | Complementary waveform output |
| running_o | output | 1 | Channel enable state, cleared by software or at the end of a count |
| irq_o | output | 1 | Sticky pulse-count-done flag |

## Verification
Two situations are hard to reach from the ports: a configuration write that lands strictly inside a running period, and a pulse count whose upper bits are nonzero. In the first case, a compare write is issued on the edge right after the start, so it lands while the first period is still in progress. The old compare value must then still be visible on the very next cycle, and the new one must appear only in later periods. In the second case, a count of 257 with a two-tick period drives the internal pulse counter past its low byte. Every cycle is also compared against a behavioural model, which catches any slip of the stop edge by one cycle.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 8;
    localparam int NUM_W  = 14;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int NUM_LO_W = 8;

    localparam logic [ADDR_W-1:0] A_DIV    = 4'h0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 4'h1;
    localparam logic [ADDR_W-1:0] A_CMP    = 4'h2;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'h3;
    localparam logic [ADDR_W-1:0] A_OUTCFG = 4'h4;
    localparam logic [ADDR_W-1:0] A_NUM_LO = 4'h5;
    localparam logic [ADDR_W-1:0] A_NUM_HI = 4'h6;
    localparam logic [ADDR_W-1:0] A_ENABLE = 4'h7;
    localparam logic [ADDR_W-1:0] A_IRQCLR = 4'h8;

    typedef enum logic {
        MODE_FREE  = 1'b0,
        MODE_COUNT = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] tmax;
        logic [CNT_W-1:0] tcmp;
        run_mode_e        mode;
        logic             inv_main;
        logic             inv_comp;
        logic             pol;
        logic [NUM_W-1:0] num;
    } chan_cfg_t;

    // true when the period now ending is the last one requested
    function automatic logic last_pulse(input logic [NUM_W-1:0] done_cnt,
                                        input logic [NUM_W-1:0] target);
        return ({1'b0, done_cnt} + (NUM_W+1)'(1)) >= {1'b0, target};
    endfunction
endpackage

// File: rtl/pwm_cfg_regs.sv
`timescale 1ns/1ps
module pwm_cfg_regs
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_i,
    output chan_cfg_t         cfg_o,
    output logic              en_o,
    output logic              irq_o
);
    localparam int NUM_HI_W = NUM_W - NUM_LO_W;

    chan_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_DIV:    cfg_q.div  <= wr_data[DIV_W-1:0];
                A_PERIOD: cfg_q.tmax <= wr_data[CNT_W-1:0];
                A_CMP:    cfg_q.tcmp <= wr_data[CNT_W-1:0];
                A_MODE:   cfg_q.mode <= run_mode_e'(wr_data[0]);
                A_OUTCFG: begin
                    cfg_q.inv_main <= wr_data[0];
                    cfg_q.inv_comp <= wr_data[1];
                    cfg_q.pol      <= wr_data[2];
                end
                A_NUM_LO: cfg_q.num[NUM_LO_W-1:0]     <= wr_data[NUM_LO_W-1:0];
                A_NUM_HI: cfg_q.num[NUM_W-1:NUM_LO_W] <= wr_data[NUM_HI_W-1:0];
                default:  ;
            endcase
        end
    end

    // end of count wins over a software write on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= 1'b0;
        end else if (done_i) begin
            en_o <= 1'b0;
        end else if (wr_en && wr_addr == A_ENABLE) begin
            en_o <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else if (done_i) begin
            irq_o <= 1'b1;
        end else if (wr_en && wr_addr == A_IRQCLR && wr_data[0]) begin
            irq_o <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] pre_q;

    // >= keeps the tick alive when the divider shrinks mid-count
    assign tick_o = run_i && (pre_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_wave_core.sv
`timescale 1ns/1ps
module pwm_wave_core
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  chan_cfg_t        cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_max_o,
    output logic             done_o,
    output logic             pwm_o,
    output logic             pwm_n_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_max_q;
    logic [CNT_W-1:0] act_cmp_q;
    logic [NUM_W-1:0] pulses_q;
    logic             wrap;
    logic             lvl;

    assign wrap   = run_i && tick_i && (cnt_q == act_max_q);
    assign done_o = wrap && (cfg_i.mode == MODE_COUNT) && last_pulse(pulses_q, cfg_i.num);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q     <= '0;
            pulses_q  <= '0;
            act_max_q <= cfg_i.tmax;
            act_cmp_q <= cfg_i.tcmp;
        end else if (tick_i) begin
            if (wrap) begin
                cnt_q     <= '0;
                act_max_q <= cfg_i.tmax;
                act_cmp_q <= cfg_i.tcmp;
                if (cfg_i.mode == MODE_COUNT) begin
                    pulses_q <= pulses_q + NUM_W'(1);
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign lvl     = (cnt_q < act_cmp_q) ^ cfg_i.pol;
    assign pwm_o   = (run_i &  lvl) ^ cfg_i.inv_main;
    assign pwm_n_o = (run_i & ~lvl) ^ cfg_i.inv_comp;

    assign cnt_o     = cnt_q;
    assign act_max_o = act_max_q;
endmodule

// File: rtl/pwm_pulse_channel.sv
`timescale 1ns/1ps
module pwm_pulse_channel
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_o,
    output logic              pwm_n_o,
    output logic              running_o,
    output logic              irq_o
);
    chan_cfg_t        cfg;
    logic             en;
    logic             tick;
    logic             done;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_max;

    pwm_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .done_i  (done),
        .cfg_o   (cfg),
        .en_o    (en),
        .irq_o   (irq_o)
    );

    pwm_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (en),
        .div_i  (cfg.div),
        .tick_o (tick)
    );

    pwm_wave_core u_core (
        .clk       (clk),
        .rst       (rst),
        .run_i     (en),
        .tick_i    (tick),
        .cfg_i     (cfg),
        .cnt_o     (cnt),
        .act_max_o (act_max),
        .done_o    (done),
        .pwm_o     (pwm_o),
        .pwm_n_o   (pwm_n_o)
    );

    assign running_o = en;
endmodule

// File: rtl/pwm_chan_checker.sv
`timescale 1ns/1ps
module pwm_chan_checker
    import pwm_chan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              pwm_o,
    input logic              pwm_n_o,
    input logic              running_o,
    input logic              irq_o,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_max,
    input logic              inv_m,
    input logic              inv_n
);
    logic clr_req;
    assign clr_req = wr_en && (wr_addr == A_IRQCLR) && wr_data[0];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        running_o |-> (cnt <= act_max)) else $error("cnt past period"); // R3

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        running_o |-> ((pwm_o ^ inv_m) != (pwm_n_o ^ inv_n))) else $error("outputs not complementary"); // R3

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running_o && !tick) |=> (!running_o || $stable(cnt))) else $error("counter moved without tick"); // R2

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running_o && !(tick && cnt == act_max)) |=> (!running_o || $stable(act_max))) else $error("period changed mid-period"); // R9

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $fell(running_o)) else $error("flag without stop"); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_req) |=> irq_o) else $error("flag dropped by itself"); // R8

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !running_o |-> (pwm_o == inv_m && pwm_n_o == inv_n)) else $error("stopped outputs not idle"); // R5
endmodule

bind pwm_pulse_channel pwm_chan_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pwm_o     (pwm_o),
    .pwm_n_o   (pwm_n_o),
    .running_o (running_o),
    .irq_o     (irq_o),
    .tick      (tick),
    .cnt       (cnt),
    .act_max   (act_max),
    .inv_m     (cfg.inv_main),
    .inv_n     (cfg.inv_comp)
);

// File: tb/pwm_pulse_channel_bench.sv
`timescale 1ns/1ps
module pwm_pulse_channel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_o, pwm_n_o, running_o, irq_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done_flag = 0;

    always #4 clk = ~clk;

    pwm_pulse_channel u_pwm_pulse_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_o(pwm_o), .pwm_n_o(pwm_n_o), .running_o(running_o), .irq_o(irq_o)
    );

    // behavioural reference: integers only, updated once per rising edge
    int m_div, m_tmax, m_tcmp, m_mode, m_invm, m_invc, m_pol, m_num;
    int m_en, m_irq, m_pre, m_cnt, m_amax, m_acmp, m_pulses;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_tmax = 0; m_tcmp = 0; m_mode = 0; m_invm = 0; m_invc = 0;
            m_pol = 0; m_num = 0; m_en = 0; m_irq = 0; m_pre = 0; m_cnt = 0;
            m_amax = 0; m_acmp = 0; m_pulses = 0;
        end else begin
            bit tk, wp, fin;
            tk  = (m_en != 0) && (m_pre >= m_div);
            wp  = tk && (m_cnt == m_amax);
            fin = wp && (m_mode == 1) && (m_pulses + 1 >= m_num);
            if (m_en == 0) begin
                m_pre = 0; m_cnt = 0; m_pulses = 0; m_amax = m_tmax; m_acmp = m_tcmp;
            end else begin
                m_pre = tk ? 0 : m_pre + 1;
                if (tk) begin
                    if (wp) begin
                        m_cnt = 0; m_amax = m_tmax; m_acmp = m_tcmp;
                        if (m_mode == 1) m_pulses++;
                    end else m_cnt++;
                end
            end
            if (fin) begin
                m_en = 0; m_irq = 1;
            end else begin
                if (wr_en && wr_addr == 4'h7) m_en = wr_data[0];
                if (wr_en && wr_addr == 4'h8 && wr_data[0]) m_irq = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'h0: m_div  = wr_data[7:0];
                    4'h1: m_tmax = wr_data;
                    4'h2: m_tcmp = wr_data;
                    4'h3: m_mode = wr_data[0];
                    4'h4: begin m_invm = wr_data[0]; m_invc = wr_data[1]; m_pol = wr_data[2]; end
                    4'h5: m_num = (m_num & 16'h3F00) | wr_data[7:0];
                    4'h6: m_num = (m_num & 16'h00FF) | (int'(wr_data[5:0]) << 8);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int lvl, em, ec;
            lvl = ((m_cnt < m_acmp) ? 1 : 0) ^ m_pol;
            em  = (m_en != 0) ? (lvl ^ m_invm) : m_invm;
            ec  = (m_en != 0) ? ((1 - lvl) ^ m_invc) : m_invc;
            checks++;
            if (pwm_o !== 1'(em) || pwm_n_o !== 1'(ec) || running_o !== 1'(m_en) || irq_o !== 1'(m_irq)) begin
                errors++;
                $display("FAIL %s model mismatch actual=%b%b%b%b expected=%0d%0d%0d%0d",
                         cur_req, pwm_o, pwm_n_o, running_o, irq_o, em, ec, m_en, m_irq);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic count_highs(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
    endtask

    task automatic count_until_stop(input int limit, output int rises);
        bit prev;
        rises = 0;
        prev = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!running_o) break;
            if (pwm_o && !prev) rises++;
            prev = pwm_o;
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int h, r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset levels
        chk("R1", "pwm_o", pwm_o, 0);
        chk("R1", "pwm_n_o", pwm_n_o, 0);
        chk("R1", "running_o", running_o, 0);
        chk("R1", "irq_o", irq_o, 0);

        // R3 basic waveform, period 5 ticks, high 2
        cur_req = "R3";
        wr(4'h0, 16'd0); wr(4'h1, 16'd4); wr(4'h2, 16'd2); wr(4'h3, 16'h00);
        wr(4'h7, 16'd1);
        count_highs(50, h);
        chk("R3", "high cycles in 10 periods", h, 20);

        // R2 divider 2: period 15 cycles, high 6
        cur_req = "R2";
        wr(4'h0, 16'd2);
        repeat (20) @(negedge clk);
        count_highs(45, h);
        chk("R2", "high cycles with divider 2", h, 18);

        // R4 polarity swaps level order
        cur_req = "R4";
        wr(4'h4, 16'h0004);
        repeat (20) @(negedge clk);
        count_highs(45, h);
        chk("R4", "high cycles with polarity", h, 27);

        // R10 stop, outputs idle
        cur_req = "R10";
        wr(4'h4, 16'h0000);
        wr(4'h7, 16'd0);
        @(negedge clk);
        chk("R10", "running after stop", running_o, 0);
        chk("R10", "pwm_o after stop", pwm_o, 0);

        // R5 independent inversion while stopped
        cur_req = "R5";
        wr(4'h4, 16'h0001);
        @(negedge clk);
        chk("R5", "pwm_o inverted idle", pwm_o, 1);
        chk("R5", "pwm_n_o unaffected", pwm_n_o, 0);
        wr(4'h4, 16'h0002);
        @(negedge clk);
        chk("R5", "pwm_o uninverted idle", pwm_o, 0);
        chk("R5", "pwm_n_o inverted idle", pwm_n_o, 1);
        wr(4'h4, 16'h0000);

        // R10 restart from counter 0: first cycle high
        cur_req = "R10";
        wr(4'h0, 16'd0); wr(4'h7, 16'd1);
        @(negedge clk);
        chk("R10", "restart begins high", pwm_o, 1);
        wr(4'h7, 16'd0);

        // R9 compare written mid-period waits for boundary
        cur_req = "R9";
        wr(4'h1, 16'd9); wr(4'h2, 16'd5);
        wr(4'h7, 16'd1);
        wr(4'h2, 16'd1);
        @(negedge clk);
        chk("R9", "old compare still active", pwm_o, 1);
        repeat (10) @(negedge clk);
        count_highs(20, h);
        chk("R9", "new compare after boundary", h, 2);
        wr(4'h7, 16'd0);

        // R6 continuous mode keeps running
        cur_req = "R6";
        wr(4'h1, 16'd1); wr(4'h2, 16'd1);
        wr(4'h7, 16'd1);
        repeat (300) @(negedge clk);
        chk("R6", "still running in mode 0x00", running_o, 1);
        chk("R6", "no flag in mode 0x00", irq_o, 0);
        wr(4'h7, 16'd0);

        // R7 counting mode, N=3
        cur_req = "R7";
        wr(4'h1, 16'd3); wr(4'h2, 16'd1); wr(4'h3, 16'h01);
        wr(4'h5, 16'd3); wr(4'h6, 16'd0);
        wr(4'h7, 16'd1);
        count_until_stop(200, r);
        chk("R7", "periods emitted N=3", r, 3);
        chk("R7", "flag raised at stop", irq_o, 1);
        chk("R7", "enable cleared", running_o, 0);

        // R8 sticky flag
        cur_req = "R8";
        wr(4'h8, 16'd0);
        @(negedge clk);
        chk("R8", "write 0 leaves flag", irq_o, 1);
        wr(4'h8, 16'd1);
        @(negedge clk);
        chk("R8", "write 1 clears flag", irq_o, 0);

        // R7 N=0 gives one period
        cur_req = "R7";
        wr(4'h5, 16'd0);
        wr(4'h7, 16'd1);
        count_until_stop(200, r);
        chk("R7", "periods emitted N=0", r, 1);
        wr(4'h8, 16'd1);

        // R11 count with upper bits: 0x101
        cur_req = "R11";
        wr(4'h1, 16'd1); wr(4'h2, 16'd1);
        wr(4'h5, 16'h01); wr(4'h6, 16'h01);
        wr(4'h7, 16'd1);
        count_until_stop(2000, r);
        chk("R11", "periods emitted N=257", r, 257);
        chk("R11", "flag after long count", irq_o, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule